// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the processor side of a coprocessor attachment. It carries one coprocessor-class instruction through a three-wire handshake. The processor drives an active-low instruction line. An attached coprocessor answers on two lines, absent and busy, and both of them idle high.

Once the instruction has passed its condition test, the sequencer lowers the instruction line. It then waits while the coprocessor is busy, and ends in exactly one outcome:
- **commit**: the coprocessor claims the instruction and is ready;
- **undefined trap**: no coprocessor claims the instruction;
- **interrupted**: an enabled interrupt breaks off the busy-wait, and the instruction is later issued again.

A committed memory-transfer instruction opens a transfer phase. The phase presents a word address that steps by four bytes per cycle until the coprocessor ends it.

Some instructions trap at once without touching the lines: those that are not in the coprocessor class, and all instructions issued while the processor runs its compact 16-bit instruction state. A transfer that runs past a fixed word limit is cut off and flagged as a protocol violation.

Top module: `cp_handshake_seq`

## Requirements
- R1: After a synchronous active-low reset, `cp_instr_n` is high, `xfer_active` is low and all outcome pulses (`done_commit`, `done_undef`, `done_intr`, `xfer_overrun`) are low.
- R2: An issue strobe with `issue_cond_ok` low is dropped. The sequencer stays idle, `cp_instr_n` stays high and no outcome pulse appears.
- R3: A condition-passing issue traps at once in two cases: instruction bit 27 is clear, or `compact_state` is high. In both cases `done_undef` pulses in the cycle after the strobe and `cp_instr_n` never goes low.
- R4: Any other condition-passing issue drives `cp_instr_n` low from the cycle after the strobe. The line stays low until an outcome is taken.
- R5: While `cp_instr_n` is low, sampling `cp_absent` high (with busy high or low) gives a `done_undef` pulse in the next cycle, and `cp_instr_n` returns high.
- R6: While `cp_instr_n` is low, `cp_absent` low together with `cp_busy` high and no pending interrupt keeps the sequencer waiting. The line stays low and no outcome pulse appears, for any number of cycles.
- R7: If `irq_pend` is sampled high during the busy-wait of R6, `done_intr` pulses in the next cycle and `cp_instr_n` returns high. When absent and busy are both low, a pending interrupt is ignored and the instruction commits.
- R8: Sampling `cp_absent` and `cp_busy` both low while `cp_instr_n` is low gives a `done_commit` pulse in the next cycle and raises `cp_instr_n`. At most one outcome pulse is high in any cycle.
- R9: A committed instruction whose bits 27:25 equal 3'b110 starts a transfer phase in the cycle of the commit pulse. `xfer_addr` starts at the `xfer_base` value sampled with the issue strobe and increases by 4 each following cycle. `xfer_to_cp` equals instruction bit 20. Committed instructions with any other class bits have no transfer phase.
- R10: During the transfer phase, every rising edge retires one word. The phase ends after the word in whose cycle `cp_absent` and `cp_busy` are both sampled high, so a transfer has at least one word.
- R11: If the sixteenth word retires (default `MAX_WORDS`) without the end condition, `xfer_overrun` pulses in the next cycle and the sequencer returns to idle.
- R12: The issue strobe is ignored while an instruction is in flight. A new strobe is accepted in the first cycle after any outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | One-cycle strobe presenting an instruction |
| issue_instr | input | 32 | Instruction word |
| issue_cond_ok | input | 1 | Condition test result for the instruction |
| compact_state | input | 1 | High while the processor runs 16-bit instructions |
| xfer_base | input | ADDR_W | First transfer address, sampled with the strobe |
| cp_absent | input | 1 | Coprocessor absent line, idles high, pulled low to claim |
| cp_busy | input | 1 | Coprocessor busy line, idles high |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cp_instr_n | output | 1 | Active-low coprocessor instruction line |
| done_commit | output | 1 | Pulse: instruction committed |
| done_undef | output | 1 | Pulse: undefined-instruction trap |
| done_intr | output | 1 | Pulse: handshake abandoned for an interrupt |
| xfer_overrun | output | 1 | Pulse: transfer exceeded the word limit |
| xfer_active | output | 1 | Transfer phase in progress |
| xfer_to_cp | output | 1 | Transfer direction (instruction bit 20) |
| xfer_addr | output | ADDR_W | Current transfer word address |

## Verification
The hardest situation to reach is the word-limit overrun. It needs a committed transfer-class instruction and a coprocessor that holds its lines low for sixteen consecutive words. The bench gets there by sweeping the end cycle from one word up to past the limit, and by checking the address on every word. Interrupt break-off and the commit-over-interrupt priority are reached by holding a busy-wait for several lengths before releasing busy or raising the interrupt. A stray strobe issued during that wait shows that in-flight instructions ignore it.

// File: rtl/cphs_pkg.sv
// Package: shared types for the coprocessor handshake sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cphs_pkg;

    // Sequencer phase.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } seq_state_t;

    // Classification of an issued instruction.
    typedef struct packed {
        logic trap_now;   // trap without handshake
        logic has_xfer;   // memory-transfer class
        logic to_cp;      // direction bit
    } instr_class_t;

endpackage

// File: rtl/cphs_decode.sv
// Module: cphs_decode
// Classifies an instruction word for the handshake sequencer.
// Assumes: the field positions given by the parameters; purely combinational.
module cphs_decode
    import cphs_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int CLASS_HI = 27,
    parameter int DIR_BIT  = 20
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               compact,
    output instr_class_t       cls
);
    localparam int CLASS_LO = CLASS_HI - 2;

    // Derive trap, transfer-class and direction flags.
    always_comb begin
        cls.trap_now = !instr[CLASS_HI] || compact;
        cls.has_xfer = (instr[CLASS_HI:CLASS_LO] == 3'b110);
        cls.to_cp    = instr[DIR_BIT];
    end
endmodule

// File: rtl/cphs_xfer.sv
// Module: cphs_xfer
// Holds the transfer word address and the count of retired words.
// Assumes: capture loads the base and count 1; advance retires one word.
module cphs_xfer #(
    parameter int ADDR_W     = 32,
    parameter int MAX_WORDS  = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr,
    output logic              at_limit
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);
    localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(MAX_WORDS);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(WORD_BYTES);

    logic [CNT_W-1:0] cnt;

    // Address and word-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            cnt  <= '0;
        end else if (capture) begin
            addr <= base;
            cnt  <= CNT_W'(1);
        end else if (advance) begin
            addr <= addr + STEP;
            cnt  <= cnt + CNT_W'(1);
        end
    end

    // Flag that the current word is the last one allowed.
    always_comb at_limit = (cnt == CNT_MAX);
endmodule

// File: rtl/cphs_ctrl.sv
// Module: cphs_ctrl
// Handshake state machine: issue, busy-wait, outcome and transfer phase.
// Assumes: lines are sampled on the rising edge; outcome pulses are registered.
module cphs_ctrl
    import cphs_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_vld,
    input  logic         cond_ok,
    input  instr_class_t cls,
    input  logic         cp_absent,
    input  logic         cp_busy,
    input  logic         irq_pend,
    input  logic         at_limit,
    output seq_state_t   st,
    output logic         capture,
    output logic         advance,
    output logic         to_cp_q,
    output logic         done_commit,
    output logic         done_undef,
    output logic         done_intr,
    output logic         overrun
);
    seq_state_t nxt;
    logic has_xfer_q;
    logic o_commit, o_undef, o_intr, o_ovf;

    // Next-state and outcome decision.
    always_comb begin
        nxt      = st;
        capture  = 1'b0;
        advance  = 1'b0;
        o_commit = 1'b0;
        o_undef  = 1'b0;
        o_intr   = 1'b0;
        o_ovf    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (issue_vld && cond_ok) begin
                    if (cls.trap_now) begin
                        o_undef = 1'b1;
                    end else begin
                        nxt     = ST_WAIT;
                        capture = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (cp_absent) begin
                    o_undef = 1'b1;
                    nxt     = ST_IDLE;
                end else if (!cp_busy) begin
                    o_commit = 1'b1;
                    nxt      = has_xfer_q ? ST_XFER : ST_IDLE;
                end else if (irq_pend) begin
                    o_intr = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            ST_XFER: begin
                if (cp_absent && cp_busy) begin
                    nxt = ST_IDLE;
                end else if (at_limit) begin
                    o_ovf = 1'b1;
                    nxt   = ST_IDLE;
                end else begin
                    advance = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, captured class bits and registered outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            has_xfer_q  <= 1'b0;
            to_cp_q     <= 1'b0;
            done_commit <= 1'b0;
            done_undef  <= 1'b0;
            done_intr   <= 1'b0;
            overrun     <= 1'b0;
        end else begin
            st          <= nxt;
            done_commit <= o_commit;
            done_undef  <= o_undef;
            done_intr   <= o_intr;
            overrun     <= o_ovf;
            if (capture) begin
                has_xfer_q <= cls.has_xfer;
                to_cp_q    <= cls.to_cp;
            end
        end
    end
endmodule

// File: rtl/cp_handshake_seq.sv
// Module: cp_handshake_seq (top)
// Runs the absent/busy handshake for one coprocessor instruction at a time
// and sequences a coprocessor-terminated word transfer.
// Assumes: synchronous active-low reset; external lines already synchronised.
module cp_handshake_seq
    import cphs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int MAX_WORDS  = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [31:0]       issue_instr,
    input  logic              issue_cond_ok,
    input  logic              compact_state,
    input  logic [ADDR_W-1:0] xfer_base,
    input  logic              cp_absent,
    input  logic              cp_busy,
    input  logic              irq_pend,
    output logic              cp_instr_n,
    output logic              done_commit,
    output logic              done_undef,
    output logic              done_intr,
    output logic              xfer_overrun,
    output logic              xfer_active,
    output logic              xfer_to_cp,
    output logic [ADDR_W-1:0] xfer_addr
);
    instr_class_t cls;
    seq_state_t   st;
    logic capture, advance, at_limit;

    cphs_decode #(.INSTR_W(32), .CLASS_HI(27), .DIR_BIT(20)) u_dec (
        .instr   (issue_instr),
        .compact (compact_state),
        .cls     (cls)
    );

    cphs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_vld   (issue_vld),
        .cond_ok     (issue_cond_ok),
        .cls         (cls),
        .cp_absent   (cp_absent),
        .cp_busy     (cp_busy),
        .irq_pend    (irq_pend),
        .at_limit    (at_limit),
        .st          (st),
        .capture     (capture),
        .advance     (advance),
        .to_cp_q     (xfer_to_cp),
        .done_commit (done_commit),
        .done_undef  (done_undef),
        .done_intr   (done_intr),
        .overrun     (xfer_overrun)
    );

    cphs_xfer #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS), .WORD_BYTES(WORD_BYTES)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .advance  (advance),
        .base     (xfer_base),
        .addr     (xfer_addr),
        .at_limit (at_limit)
    );

    // Line and phase outputs decoded from the registered state.
    always_comb begin
        cp_instr_n  = (st != ST_WAIT);
        xfer_active = (st == ST_XFER);
    end
endmodule

// File: rtl/cphs_checker.sv
// Module: cphs_checker
// Temporal checks on the sequencer ports, attached to every instance by bind.
// Assumes: same port names as the top module.
module cphs_checker #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_vld,
    input logic [31:0]       issue_instr,
    input logic              issue_cond_ok,
    input logic              compact_state,
    input logic [ADDR_W-1:0] xfer_base,
    input logic              cp_absent,
    input logic              cp_busy,
    input logic              irq_pend,
    input logic              cp_instr_n,
    input logic              done_commit,
    input logic              done_undef,
    input logic              done_intr,
    input logic              xfer_overrun,
    input logic              xfer_active,
    input logic              xfer_to_cp,
    input logic [ADDR_W-1:0] xfer_addr
);
    logic idle_now;
    always_comb idle_now = cp_instr_n && !xfer_active;

    // R1: reset leaves the line high and no transfer.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cp_instr_n && !xfer_active && !done_commit && !done_undef));

    // R2: a failing condition leaves everything quiet.
    p_cond_fail_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_now && issue_vld && !issue_cond_ok) |=>
            (cp_instr_n && !done_undef && !done_commit && !done_intr));

    // R5: absent sampled high while waiting yields the trap.
    p_absent_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_instr_n && cp_absent) |=> (done_undef && cp_instr_n));

    // R6: busy-wait without interrupt keeps the line low.
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_instr_n && !cp_absent && cp_busy && !irq_pend) |=>
            (!cp_instr_n && !done_intr && !done_undef && !done_commit));

    // R7: interrupt during busy-wait abandons the handshake.
    p_irq_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_instr_n && !cp_absent && cp_busy && irq_pend) |=> (done_intr && cp_instr_n));

    // R8: all three lines low commits.
    p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_instr_n && !cp_absent && !cp_busy) |=> (done_commit && cp_instr_n));

    // R8: outcomes are mutually exclusive.
    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_commit, done_undef, done_intr, xfer_overrun}));

    // R9: address steps by one word per transfer cycle.
    p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && $past(xfer_active)) |->
            (xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES)));

    // R10: both lines high during transfer ends the phase.
    p_xfer_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && cp_absent && cp_busy) |=> (!xfer_active && !xfer_overrun));
endmodule

bind cp_handshake_seq cphs_checker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/tb_cp_handshake_seq.sv
module tb_cp_handshake_seq;
    localparam int AW = 32;
    localparam int MAXW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_vld = 1'b0;
    logic [31:0] issue_instr = '0;
    logic issue_cond_ok = 1'b0;
    logic compact_state = 1'b0;
    logic [AW-1:0] xfer_base = 32'h0000_4000;
    logic cp_absent = 1'b1;
    logic cp_busy = 1'b1;
    logic irq_pend = 1'b0;
    logic cp_instr_n, done_commit, done_undef, done_intr, xfer_overrun;
    logic xfer_active, xfer_to_cp;
    logic [AW-1:0] xfer_addr;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cp_handshake_seq dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] cls, input logic dir);
        logic [31:0] w = 32'hE000_0000;
        w[27:25] = cls;
        w[20] = dir;
        return w;
    endfunction

    // Present a strobe at a negedge; returns at the next negedge.
    task automatic issue(input logic [31:0] ins, input logic cond, input logic cmp);
        issue_vld = 1'b1; issue_instr = ins; issue_cond_ok = cond; compact_state = cmp;
        @(negedge clk);
        issue_vld = 1'b0; compact_state = 1'b0;
    endtask

    function automatic logic [31:0] outs();
        return {28'd0, done_commit, done_undef, done_intr, xfer_overrun};
    endfunction

    initial begin
        #(10 * 150000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 line", {31'd0, cp_instr_n}, 1);
        chk("R1 outcomes", outs(), 0);
        chk("R1 xfer", {31'd0, xfer_active}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep class bits, direction, condition and compact state (R2 R3 R4 R8 R9 R12).
        for (int c = 0; c < 8; c++) begin
            for (int cond = 0; cond < 2; cond++) begin
                for (int cmp = 0; cmp < 2; cmp++) begin
                    logic [31:0] w;
                    logic trap, hx;
                    w = mk(3'(c), c[0] ^ cmp[0]);
                    trap = !w[27] || cmp[0];
                    hx = (w[27:25] == 3'b110);
                    xfer_base = 32'h0000_1000 + 32'(c * 64);
                    cp_absent = 1'b0; cp_busy = 1'b0;
                    issue(w, cond[0], cmp[0]);
                    if (!cond[0]) begin
                        chk("R2 line", {31'd0, cp_instr_n}, 1);
                        chk("R2 outcomes", outs(), 0);
                    end else if (trap) begin
                        chk("R3 undef", outs(), 32'h4);
                        chk("R3 line", {31'd0, cp_instr_n}, 1);
                    end else begin
                        chk("R4 line low", {31'd0, cp_instr_n}, 0);
                        @(negedge clk);
                        chk("R8 commit", outs(), 32'h8);
                        chk("R8 line high", {31'd0, cp_instr_n}, 1);
                        chk("R9 phase", {31'd0, xfer_active}, {31'd0, hx});
                        if (hx) begin
                            chk("R9 base", xfer_addr, xfer_base);
                            chk("R9 dir", {31'd0, xfer_to_cp}, {31'd0, w[20]});
                            cp_absent = 1'b1; cp_busy = 1'b1;
                            @(negedge clk);
                            chk("R10 one word", {31'd0, xfer_active}, 0);
                        end
                    end
                    cp_absent = 1'b1; cp_busy = 1'b1;
                end
            end
        end

        // Transfer length sweep 1..17 words (R9 R10 R11).
        for (int n = 1; n <= MAXW + 1; n++) begin
            xfer_base = 32'h0000_8000 + 32'(n * 256);
            issue(mk(3'b110, n[0]), 1'b1, 1'b0);
            cp_absent = 1'b0; cp_busy = 1'b0;
            @(negedge clk);
            chk("R9 start", xfer_addr, xfer_base);
            for (int k = 1; k <= MAXW; k++) begin
                if (k == n) begin cp_absent = 1'b1; cp_busy = 1'b1; end
                else if (k[1]) begin cp_absent = 1'b0; cp_busy = 1'b1; end
                else begin cp_absent = 1'b0; cp_busy = 1'b0; end
                @(negedge clk);
                if (k == n) begin
                    chk("R10 end", {30'd0, xfer_active, xfer_overrun}, 0);
                    break;
                end else if (k == MAXW) begin
                    chk("R11 overrun", {30'd0, xfer_active, xfer_overrun}, 1);
                end else begin
                    chk("R9 step", xfer_addr, xfer_base + 32'(4 * k));
                end
            end
            cp_absent = 1'b1; cp_busy = 1'b1;
            @(negedge clk);
            chk("R11 single pulse", outs(), 0);
        end

        // Busy-wait lengths ending in release or interrupt (R6 R7 R12).
        for (int len = 1; len <= 7; len += 3) begin
            for (int ending = 0; ending < 3; ending++) begin
                issue(mk(3'b111, 1'b0), 1'b1, 1'b0);
                cp_absent = 1'b0; cp_busy = 1'b1;
                for (int i = 0; i < len; i++) begin
                    if (i == 0) begin issue_vld = 1'b1; issue_instr = 32'h0; issue_cond_ok = 1'b1; end
                    @(negedge clk);
                    issue_vld = 1'b0;
                    chk("R6 hold line", {31'd0, cp_instr_n}, 0);
                    chk("R6 R12 no outcome", outs(), 0);
                end
                if (ending == 0) begin
                    irq_pend = 1'b1;
                    @(negedge clk);
                    chk("R7 intr", outs(), 32'h2);
                    chk("R7 line", {31'd0, cp_instr_n}, 1);
                end else if (ending == 1) begin
                    irq_pend = 1'b1; cp_busy = 1'b0;
                    @(negedge clk);
                    chk("R7 commit wins", outs(), 32'h8);
                end else begin
                    cp_busy = 1'b0;
                    @(negedge clk);
                    chk("R8 commit after wait", outs(), 32'h8);
                end
                irq_pend = 1'b0; cp_absent = 1'b1; cp_busy = 1'b1;
            end
        end

        // No coprocessor claims: absent high with busy high or low (R5).
        for (int b = 0; b < 2; b++) begin
            issue(mk(3'b111, 1'b1), 1'b1, 1'b0);
            chk("R4 line low", {31'd0, cp_instr_n}, 0);
            cp_absent = 1'b1; cp_busy = b[0]; irq_pend = 1'b1;
            @(negedge clk);
            chk("R5 undef", outs(), 32'h4);
            chk("R5 line", {31'd0, cp_instr_n}, 1);
            irq_pend = 1'b0; cp_busy = 1'b1;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule